// File: doc/BRIEF.md
# Power-Management I/O Window and System Control Interrupt

This block owns a small, relocatable power-management register window in I/O space and turns latched wake and timer events into a level-sensitive system control interrupt. Software programs the window base and its enable bit through configuration-space dword writes. It then reaches two 16-bit registers through the window. The first is an event status register whose bits are cleared by writing one. The second is an event enable register.

Four event sources are latched: timer overflow, global lock release, power button and real-time-clock alarm. Each has a one-cycle input pulse. The interrupt is the OR of these latched bits, each qualified by its own enable bit. A second level output asks the timer logic outside the block to arm its overflow event. It is high while the timer event is enabled and not yet pending.

Top module: `pm_sci_window`

## Requirements
- R1: After reset the configuration dwords read as follows: 0x40 reads 0, 0x80 reads 0, 0x48 reads 0x00000001 and 0xD0 reads 0x00900000 (byte 0xD2 holds 0x90). Any other dword reads 0. The status and enable registers are 0, `sci` is 0 and `tmr_arm` is 0.
- R2: The window base is bits 15:0 of configuration dword 0x40 with the low six bits forced to 0. Bits above 15 are stored but play no part in decode. An access hits when `io_addr[15:6]` equals `base[15:6]`.
- R3: The window responds only when bit 0 of configuration dword 0x80 is set and the base is non-zero. Otherwise `io_hit` stays 0, `io_rdata` reads 0 and writes change nothing.
- R4: A configuration write takes effect at the next clock edge. It selects a dword by `cfg_addr[7:2]`, and all four writable dwords (0x40, 0x48, 0x80, 0xD0) store all 32 bits.
- R5: Inside the window, `io_addr[5:1]` = 0 selects the status register and `io_addr[5:1]` = 1 selects the enable register. Other offsets read 0 and ignore writes. `io_rdata` carries the selected register only while `io_rd_en` and `io_hit` are both high.
- R6: Status is write-one-to-clear. A written 1 clears that bit and a written 0 leaves it unchanged. Only bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist, and all other status bits read 0.
- R7: `evt_pulse[0..3]` (timer, global lock, power button, RTC) set status bits 0, 5, 8 and 10. When an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R8: `sci` is high exactly when at least one of status bits 0, 5, 8 and 10 is set together with the same enable bit. Enable bits at other positions have no effect on `sci`.
- R9: `tmr_arm` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R10: `sci` and `tmr_arm` follow the registers with no added delay. They change in the cycle after the edge that updates status or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration dword write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword by bits 7:2) for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| io_rd_en | input | 1 | I/O read strobe |
| io_wr_en | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, 0 when not hit |
| io_hit | output | 1 | Access falls in the enabled window |
| evt_pulse | input | 4 | Event pulses: timer, global lock, power button, RTC |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Request to arm the timer overflow event |

## Verification
The bench targets three window cases: a zero base with the enable set, a base with only its low six bits set, and addresses one byte past either end of the window. A decoder that skipped the zero-base test or the alignment mask would answer at the wrong addresses. The bench also fires an event in the same cycle that software clears its bit; a design that let the clear win would lose that interrupt. Further checks use enable bits outside the four sources, and they hold or release the timer enable around a pending timer bit. A mask that was too wide would raise a spurious interrupt, and an inverted arm term would re-arm the timer while the event was still pending.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_AW   = 16;   // I/O address width
  localparam int WIN_LG  = 6;    // log2 of window size in bytes
  localparam int CFG_DW  = 32;   // configuration dword width
  localparam int NSRC    = 4;    // number of event sources
  localparam int NSLOT   = 4;    // writable configuration dwords

  typedef enum logic [1:0] {SEL_NONE, SEL_STS, SEL_EN} reg_sel_e;

  // status bit position owned by each event source
  function automatic int src_bit(input int i);
    case (i)
      0: return 0;    // timer overflow
      1: return 5;    // global lock
      2: return 8;    // power button
      default: return 10; // RTC alarm
    endcase
  endfunction

  function automatic logic [PM_AW-1:0] src_mask();
    logic [PM_AW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction

  // configuration dword address of each storage slot
  function automatic logic [5:0] slot_dw(input int i);
    case (i)
      0: return 6'h10; // 0x40 window base
      1: return 6'h12; // 0x48 misc, resets to 1
      2: return 6'h20; // 0x80 window enable in bit 0
      default: return 6'h34; // 0xD0, byte 0xD2 resets to 0x90
    endcase
  endfunction

  function automatic logic [CFG_DW-1:0] slot_rst(input int i);
    case (i)
      1: return 32'h0000_0001;
      3: return 32'h0090_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PM_AW-1:0] win_base(input logic [CFG_DW-1:0] cfg);
    return cfg[PM_AW-1:0] & ~PM_AW'((1 << WIN_LG) - 1);
  endfunction

  function automatic logic in_window(input logic [PM_AW-1:0] addr,
                                     input logic [PM_AW-1:0] base);
    return addr[PM_AW-1:WIN_LG] == base[PM_AW-1:WIN_LG];
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic              win_en,
  output logic [PM_AW-1:0]  win_base_o
);
  logic [CFG_DW-1:0] slot_q [NSLOT];
  logic [NSLOT-1:0]  slot_hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_hit[g] = (addr[7:2] == slot_dw(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   slot_q[g] <= slot_rst(g);
      else if (wr_en && slot_hit[g]) slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_hit[i]) rdata = slot_q[i];
  end

  assign win_en     = slot_q[2][0];
  assign win_base_o = win_base(slot_q[0]);
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_pkg::*;
(
  input  logic [PM_AW-1:0] io_addr,
  input  logic             io_rd_en,
  input  logic             io_wr_en,
  input  logic             win_en,
  input  logic [PM_AW-1:0] base,
  output logic             hit,
  output reg_sel_e         sel
);
  logic live;
  assign live = win_en && (base != '0);
  assign hit  = live && (io_rd_en || io_wr_en) && in_window(io_addr, base);

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      case (io_addr[WIN_LG-1:1])
        '0:        sel = SEL_STS;
        5'd1:      sel = SEL_EN;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic [PM_AW-1:0] wdata,
  input  logic [NSRC-1:0]  evt_pulse,
  output logic [PM_AW-1:0] sts_q,
  output logic [PM_AW-1:0] en_q,
  output logic             sci,
  output logic             tmr_arm
);
  localparam logic [PM_AW-1:0] MASK = src_mask();
  localparam int TBIT = src_bit(0);

  logic [PM_AW-1:0] evt_vec;
  always_comb begin
    evt_vec = '0;
    for (int i = 0; i < NSRC; i++) evt_vec[src_bit(i)] = evt_pulse[i];
  end

  for (genvar b = 0; b < PM_AW; b++) begin : g_sts
    if (MASK[b]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q[b] <= 1'b0;
        else        sts_q[b] <= (sts_q[b] & ~(sts_wr & wdata[b])) | evt_vec[b];
      end
    end else begin : g_tied
      assign sts_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata;
  end

  assign sci     = |(sts_q & en_q & MASK);
  assign tmr_arm = en_q[TBIT] & ~sts_q[TBIT];
endmodule

// File: rtl/pm_sci_window.sv
module pm_sci_window
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              io_rd_en,
  input  logic              io_wr_en,
  input  logic [PM_AW-1:0]  io_addr,
  input  logic [PM_AW-1:0]  io_wdata,
  output logic [PM_AW-1:0]  io_rdata,
  output logic              io_hit,
  input  logic [NSRC-1:0]   evt_pulse,
  output logic              sci,
  output logic              tmr_arm
);
  logic             win_en;
  logic [PM_AW-1:0] win_base_w;
  reg_sel_e         sel;
  logic [PM_AW-1:0] sts_q, en_q;
  logic             sts_wr, en_wr;

  pm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .win_en(win_en),
    .win_base_o(win_base_w)
  );

  pm_win_decode u_dec (
    .io_addr(io_addr), .io_rd_en(io_rd_en), .io_wr_en(io_wr_en),
    .win_en(win_en), .base(win_base_w), .hit(io_hit), .sel(sel)
  );

  assign sts_wr = io_wr_en && (sel == SEL_STS);
  assign en_wr  = io_wr_en && (sel == SEL_EN);

  pm_evt_regs u_evt (
    .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .en_wr(en_wr),
    .wdata(io_wdata), .evt_pulse(evt_pulse), .sts_q(sts_q), .en_q(en_q),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd_en) begin
      case (sel)
        SEL_STS: io_rdata = sts_q;
        SEL_EN:  io_rdata = en_q;
        default: io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pm_sci_window_chk.sv
module pm_sci_window_chk
  import pm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             io_hit,
  input logic             io_wr_en,
  input logic             win_en,
  input logic [PM_AW-1:0] win_base_w,
  input logic [PM_AW-1:0] sts_q,
  input logic [PM_AW-1:0] en_q,
  input logic             sts_wr,
  input logic [PM_AW-1:0] io_wdata,
  input logic [NSRC-1:0]  evt_pulse,
  input logic             sci,
  input logic             tmr_arm
);
  localparam logic [PM_AW-1:0] MASK = src_mask();

  // R3
  hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (win_en && win_base_w != '0));

  // R7
  timer_evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[0] |=> sts_q[0]);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && evt_pulse == '0) |=> ((sts_q & $past(io_wdata)) == '0));

  // R8
  sci_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & MASK) == '0) |-> !sci);

  // R9
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_arm |-> (en_q[0] && !sts_q[0]));

  // R6
  no_stray_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~MASK) == '0);

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr_en |=> $stable(en_q));
endmodule

bind pm_sci_window pm_sci_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_hit(io_hit), .io_wr_en(io_wr_en),
  .win_en(win_en), .win_base_w(win_base_w), .sts_q(sts_q), .en_q(en_q),
  .sts_wr(sts_wr), .io_wdata(io_wdata), .evt_pulse(evt_pulse),
  .sci(sci), .tmr_arm(tmr_arm)
);

// File: tb/test_pm_sci_window.sv
module test_pm_sci_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_rd_en = 1'b0, io_wr_en = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_hit;
  logic [3:0]  evt_pulse = '0;
  logic        sci, tmr_arm;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_base_cfg, m_misc, m_encfg, m_d0;
  logic [15:0] m_sts, m_en;

  always #10 clk = ~clk; // 50 MHz

  pm_sci_window i_pm_sci_window (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_rd_en(io_rd_en),
    .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_hit(io_hit), .evt_pulse(evt_pulse),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] bit_of(input int src);
    case (src) 0: return 16'h0001; 1: return 16'h0020; 2: return 16'h0100; default: return 16'h0400; endcase
  endfunction

  function automatic logic exp_hit();
    logic [15:0] b;
    b = {m_base_cfg[15:6], 6'b0};
    return m_encfg[0] && b != 0 && (io_rd_en || io_wr_en) && io_addr[15:6] == b[15:6];
  endfunction

  function automatic logic [15:0] exp_rdata();
    if (!(exp_hit() && io_rd_en)) return 16'h0;
    if (io_addr[5:1] == 5'd0) return m_sts;
    if (io_addr[5:1] == 5'd1) return m_en;
    return 16'h0;
  endfunction

  function automatic logic [31:0] exp_cfg(input logic [7:0] a);
    case (a[7:2])
      6'h10: return m_base_cfg;
      6'h12: return m_misc;
      6'h20: return m_encfg;
      6'h34: return m_d0;
      default: return 32'h0;
    endcase
  endfunction

  // check outputs for current inputs, then clock and advance the model
  task automatic tick();
    logic h;
    logic [15:0] ev;
    #5;
    h = exp_hit();
    chk("R2/R3 io_hit", {31'b0, io_hit}, {31'b0, h});
    chk("R5 io_rdata", {16'b0, io_rdata}, {16'b0, exp_rdata()});
    chk("R4 cfg_rdata", cfg_rdata, exp_cfg(cfg_addr));
    chk("R8 sci", {31'b0, sci}, {31'b0, |(m_sts & m_en & 16'h0521)});
    chk("R9 tmr_arm", {31'b0, tmr_arm}, {31'b0, m_en[0] & ~m_sts[0]});
    @(posedge clk);
    if (h && io_wr_en && io_addr[5:1] == 5'd0) m_sts = m_sts & ~io_wdata;
    if (h && io_wr_en && io_addr[5:1] == 5'd1) m_en = io_wdata;
    ev = 0;
    for (int i = 0; i < 4; i++) if (evt_pulse[i]) ev |= bit_of(i);
    m_sts = (m_sts | ev) & 16'h0521;
    if (cfg_wr_en) begin
      case (cfg_addr[7:2])
        6'h10: m_base_cfg = cfg_wdata;
        6'h12: m_misc = cfg_wdata;
        6'h20: m_encfg = cfg_wdata;
        6'h34: m_d0 = cfg_wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    cfg_wr_en = 0; io_rd_en = 0; io_wr_en = 0; evt_pulse = 0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d; tick();
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [15:0] d);
    io_wr_en = 1; io_addr = a; io_wdata = d; tick();
  endtask

  task automatic io_rd(input logic [15:0] a);
    io_rd_en = 1; io_addr = a; tick();
  endtask

  initial begin : watchdog
    while (cycles < 200000 && !done) begin
      @(posedge clk); cycles++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    m_base_cfg = 0; m_misc = 1; m_encfg = 0; m_d0 = 32'h0090_0000;
    m_sts = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    cfg_addr = 8'h48; #1 chk("R1 cfg 0x48", cfg_rdata, 32'h1);
    cfg_addr = 8'hD0; #1 chk("R1 cfg 0xD0", cfg_rdata, 32'h0090_0000);
    cfg_addr = 8'h40; #1 chk("R1 cfg 0x40", cfg_rdata, 32'h0);
    cfg_addr = 8'h80; #1 chk("R1 cfg 0x80", cfg_rdata, 32'h0);
    cfg_addr = 8'h44; #1 chk("R1 cfg unused", cfg_rdata, 32'h0);
    chk("R1 sci", {31'b0, sci}, 32'h0);
    chk("R1 tmr_arm", {31'b0, tmr_arm}, 32'h0);
    @(negedge clk);

    // R3 zero base with enable set: no response, write ignored
    cfg_wr(8'h80, 32'h1);
    io_wr(16'h0002, 16'hFFFF);
    io_rd(16'h0002);
    // R2 base low bits masked, upper cfg bits ignored
    cfg_wr(8'h40, 32'hABCD_003F);
    io_rd(16'h0002); // base masks to 0 -> still off (R3)
    cfg_wr(8'h40, 32'hFFFF_E07F); // base 0xE040
    io_wr(16'hE042, 16'h0FFF);    // enable all
    chk("R5 enable readback", 32'(m_en), 32'h0FFF);
    io_rd(16'hE042);
    io_rd(16'hE03F);              // one below window
    io_rd(16'hE080);              // one past window
    io_wr(16'hE044, 16'h1234);    // unused offset, ignored (R5)
    io_rd(16'hE042);
    // R8 enable bits outside sources do nothing
    io_wr(16'hE042, 16'hFADE);    // bits 0,5,8,10 clear in 0xFADE? 0xFADE & 0x0521 = 0x0000
    evt_pulse = 4'hF; tick();     // all status set (R7), sci needs enables
    io_rd(16'hE040);
    io_wr(16'hE042, 16'h0100);    // power button only -> sci (R8, R10)
    io_rd(16'hE040);
    // R7 simultaneous clear and event: bit stays set
    io_wr_en = 1; io_addr = 16'hE040; io_wdata = 16'h0100; evt_pulse = 4'b0100; tick();
    chk("R7 set wins over clear", 32'(m_sts), 32'h0521);
    io_rd(16'hE040);
    // R6 clear with zeros leaves bits, ones clear
    io_wr(16'hE040, 16'h0000);
    io_wr(16'hE040, 16'h0521);
    io_rd(16'hE040);
    // R9 timer arm around pending timer
    io_wr(16'hE042, 16'h0001);
    evt_pulse = 4'b0001; tick();
    io_wr(16'hE040, 16'h0001);
    tick();
    // R3 disable window
    cfg_wr(8'h80, 32'h0);
    io_rd(16'hE042);
    cfg_wr(8'h80, 32'h1);
    // R4 other writable dwords
    cfg_wr(8'h48, 32'hDEAD_BEEF);
    cfg_wr(8'hD1, 32'h0011_2233);
    cfg_addr = 8'hD0; tick();

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 4) == 0) evt_pulse = 4'($urandom);
      case (op)
        0: begin cfg_wr_en = 1; cfg_addr = 8'h80; cfg_wdata = {31'b0, ($urandom_range(0, 3) != 0)}; end
        1: begin cfg_wr_en = 1; cfg_addr = 8'h40;
                 cfg_wdata = ($urandom_range(0, 5) == 0) ? 32'($urandom_range(0, 63)) : $urandom; end
        2: begin cfg_addr = 8'($urandom); end
        default: begin
          io_rd_en = $urandom_range(0, 1);
          io_wr_en = !io_rd_en;
          io_addr  = ($urandom_range(0, 7) == 0) ? 16'($urandom)
                     : {m_base_cfg[15:6], 6'($urandom_range(0, 5))};
          io_wdata = ($urandom_range(0, 1) == 0) ? 16'($urandom) : 16'($urandom) & 16'h0521;
        end
      endcase
      tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule